// File: doc/BRIEF.md
# Two-Channel Timer Register Bank with Interrupt Combiner

This block is a bus slave for a 4 KB register window. It holds two identical down-counting timer channels. It decodes word addresses into per-channel register strobes and returns read data with no wait states. It drives one interrupt line per channel and a third line that is the OR of the two. Software reaches each channel through a 32-byte slot: channel 0 starts at offset 0x00 and channel 1 at 0x20. Byte-address bit 5 therefore selects the channel.

A test-override register near the top of the window can take the interrupt lines away from the channels, so that board-level wiring can be checked without running a timer. Twelve read-only identification bytes sit at the very top of the window. Every other address reads as zero and discards writes.

Each channel counts down on a prescaled tick. When its count reaches zero it does one of three things: it wraps to all-ones (free-running), it reloads from its load register (periodic), or it halts (one-shot). Each channel counts in a 16-bit or a 32-bit width.

Top module: `apb_dual_timer_bank`

## Requirements
- R1: After reset, each channel's control reads 0x10 (interrupt enable only) and its load reads 0. Its value reads 0xFFFF (the count is all-ones and the width is 16 bits). The override enable, the override outputs and all three interrupt lines are 0.
- R2: Word offsets within a channel slot are: +0x00 load, +0x04 value, +0x08 control, +0x0C interrupt clear, +0x10 raw status, +0x14 masked status, +0x18 background load.
  - A load write sets the load register and also sets the count to the written data masked to the current width.
  - A background-load write sets only the load register.
  - Both addresses read back the load register.
- R3: Control layout: bit 0 run, bit 1 periodic, bit 2 wide (32-bit count), bit 3 one-shot, bit 4 interrupt enable, bits 6:5 prescale. Control reads back bits 6:0 and reads 0 above them.
  - The count steps once every 1, 16 or 256 clocks while run is set, for a prescale of 0, 1 or 2 respectively. A prescale of 3 behaves like 2.
  - The first step comes on the Nth clock edge after the run bit is written.
- R4: On each step the count decrements within its width. A step taken at zero depends on the mode:
  - free-running: the count wraps to 0xFFFF or 0xFFFFFFFF;
  - periodic: the count reloads from the load register, masked to the width;
  - one-shot (bit 3 set): the count stays at zero.
- R5: A step from 1 to 0 sets the raw status bit. Any write to the interrupt-clear address clears it, and a step in the same cycle wins over the clear.
  - Raw status reads that bit in bit 0.
  - Masked status reads the bit ANDed with the interrupt enable.
- R6: With override off, each interrupt line equals its channel's raw bit ANDed with the enable, registered: it changes on the clock edge after the raw bit changes.
- R7: Offset 0xF00 bit 0 enables the override. Offset 0xF04 bits 1:0 drive the channel 1 and channel 0 lines while the override is on, one clock after the write. Both registers keep only these bits on readback.
- R8: The combined interrupt line always equals the OR of the two per-channel lines.
- R9: Offsets 0xFD0 to 0xFFC read, in ascending address order, 0x04, 0x00, 0x00, 0x00, 0x23, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Unmapped offsets (for example slot offset +0x1C, 0x40 and up below 0xF00, 0xF08) read 0, and writes to them change nothing.
- R11: The ready output is always 1 and the error output always 0. A write takes effect only in the access phase, when select, enable and write are all high. A setup phase alone writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 10 | Word address (byte address bits 11:2) |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| pready | output | 1 | Transfer complete, tied high |
| pslverr | output | 1 | Transfer error, tied low |
| tmr_irq_a | output | 1 | Channel 0 interrupt |
| tmr_irq_b | output | 1 | Channel 1 interrupt |
| tmr_irq_any | output | 1 | OR of the two channel interrupts |

## Verification
A write lands on the rising edge that ends its access phase. A channel that is set running on edge P0 takes its first prescaled step on edge P(N), so with no prescale the raw bit of a load of L is set on edge P(L) and the interrupt line rises on P(L+1). The override and clear writes move the lines exactly one edge after their access edge. The bench samples every line at negative edges counted from the known write edge, so it can see both the last cycle before a change and the first cycle after it. Counter results are frozen by a second control write whose access edge is a fixed three edges after the run edge. The number of steps taken is then known exactly, and the value register is read only after the channel has stopped.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
  parameter int DW      = 32;
  parameter int AW      = 10;
  parameter int NCH     = 2;
  parameter int CH_W    = (NCH > 1) ? $clog2(NCH) : 1;
  parameter int CTRL_W  = 7;
  parameter int PRE_W   = 8;
  parameter int NARROW  = 16;
  parameter int ID_CNT  = 12;
  parameter logic [AW-1:0] ITEN_WORD = 10'h3C0;
  parameter logic [AW-1:0] ITOV_WORD = 10'h3C1;
  parameter logic [AW-1:0] ID_WORD   = 10'h3F4;

  typedef struct packed {
    logic [1:0] prescale;
    logic       irq_en;
    logic       oneshot;
    logic       wide;
    logic       periodic;
    logic       run;
  } ctrl_t;

  typedef enum logic [2:0] {
    RG_LOAD   = 3'd0,
    RG_VALUE  = 3'd1,
    RG_CTRL   = 3'd2,
    RG_INTCLR = 3'd3,
    RG_RIS    = 3'd4,
    RG_MIS    = 3'd5,
    RG_BGLOAD = 3'd6,
    RG_NONE   = 3'd7
  } chreg_e;

  localparam ctrl_t CTRL_RST = '{prescale: 2'd0, irq_en: 1'b1, oneshot: 1'b0,
                                 wide: 1'b0, periodic: 1'b0, run: 1'b0};

  function automatic logic [DW-1:0] width_mask(input logic wide);
    return wide ? {DW{1'b1}} : {{(DW-NARROW){1'b0}}, {NARROW{1'b1}}};
  endfunction

  function automatic logic tick_due(input logic [1:0] pre, input logic [PRE_W-1:0] pcnt);
    case (pre)
      2'd0:    return 1'b1;
      2'd1:    return &pcnt[3:0];
      default: return &pcnt;
    endcase
  endfunction

  // count after one step: decrement, or the mode's action at zero
  function automatic logic [DW-1:0] next_count(input logic [DW-1:0] cnt_m,
                                               input logic [DW-1:0] load,
                                               input logic [DW-1:0] mask,
                                               input logic periodic);
    if (cnt_m == '0) return periodic ? (load & mask) : mask;
    return (cnt_m - 1'b1) & mask;
  endfunction

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd0:  return 8'h04;
      4'd4:  return 8'h23;
      4'd5:  return 8'hB8;
      4'd6:  return 8'h1B;
      4'd8:  return 8'h0D;
      4'd9:  return 8'hF0;
      4'd10: return 8'h05;
      4'd11: return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/dtb_decode.sv
module dtb_decode
  import dtb_pkg::*;
(
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  output logic          wr_acc,
  output logic          hit_ch,
  output logic [CH_W-1:0] ch_sel,
  output chreg_e        ch_reg,
  output logic          hit_iten,
  output logic          hit_itov,
  output logic          hit_id,
  output logic [3:0]    id_idx,
  output logic          unmapped
);
  logic [AW-1:0] id_off;

  always_comb begin
    wr_acc   = psel && penable && pwrite;
    ch_reg   = chreg_e'(paddr[2:0]);
    ch_sel   = paddr[3 +: CH_W];
    hit_ch   = (32'(paddr[AW-1:3]) < NCH) && (ch_reg != RG_NONE);
    hit_iten = (paddr == ITEN_WORD);
    hit_itov = (paddr == ITOV_WORD);
    id_off   = paddr - ID_WORD;
    hit_id   = (paddr >= ID_WORD) && (32'(id_off) < ID_CNT);
    id_idx   = id_off[3:0];
    unmapped = !(hit_ch || hit_iten || hit_itov || hit_id);
  end
endmodule

// File: rtl/dtb_channel.sv
module dtb_channel
  import dtb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_load,
  input  logic          wr_bgload,
  input  logic          wr_ctrl,
  input  logic          wr_intclr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] load_o,
  output logic [DW-1:0] value_o,
  output ctrl_t         ctrl_o,
  output logic          raw_o,
  output logic          ev_expire
);
  logic [DW-1:0]    load_q, cnt_q, mask, cnt_m, cnt_nxt;
  ctrl_t            ctrl_q;
  logic             raw_q, ev_tick, halted, step;
  logic [PRE_W-1:0] pcnt_q;

  always_comb begin
    mask      = width_mask(ctrl_q.wide);
    cnt_m     = cnt_q & mask;
    ev_tick   = ctrl_q.run && tick_due(ctrl_q.prescale, pcnt_q);
    halted    = ctrl_q.oneshot && (cnt_m == '0);
    step      = ev_tick && !halted;
    ev_expire = step && (cnt_m == DW'(1));
    cnt_nxt   = next_count(cnt_m, load_q, mask, ctrl_q.periodic);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '1;
      ctrl_q <= CTRL_RST;
      raw_q  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      if (wr_load || wr_bgload) load_q <= wdata;
      if (wr_ctrl)              ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_load)              cnt_q  <= wdata & mask;
      else if (step)            cnt_q  <= cnt_nxt;
      if (ev_expire)            raw_q  <= 1'b1;
      else if (wr_intclr)       raw_q  <= 1'b0;
      pcnt_q <= ctrl_q.run ? pcnt_q + 1'b1 : '0;
    end
  end

  assign load_o  = load_q;
  assign value_o = cnt_m;
  assign ctrl_o  = ctrl_q;
  assign raw_o   = raw_q;
endmodule

// File: rtl/dtb_irq_out.sv
module dtb_irq_out
  import dtb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           itm_en,
  input  logic [NCH-1:0] itov,
  input  logic [NCH-1:0] raw,
  input  logic [NCH-1:0] inten,
  output logic [NCH-1:0] irq_q,
  output logic           irq_any_q
);
  logic [NCH-1:0] src;

  always_comb src = itm_en ? itov : (raw & inten);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q     <= '0;
      irq_any_q <= 1'b0;
    end else begin
      irq_q     <= src;
      irq_any_q <= |src;
    end
  end
endmodule

// File: rtl/apb_dual_timer_bank.sv
module apb_dual_timer_bank
  import dtb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          pready,
  output logic          pslverr,
  output logic          tmr_irq_a,
  output logic          tmr_irq_b,
  output logic          tmr_irq_any
);
  logic            wr_acc, hit_ch, hit_iten, hit_itov, hit_id, unmapped;
  logic [CH_W-1:0] ch_sel;
  chreg_e          ch_reg;
  logic [3:0]      id_idx;

  logic            itm_en_q;
  logic [NCH-1:0]  itov_q;
  logic [DW-1:0]   ch_load  [NCH];
  logic [DW-1:0]   ch_value [NCH];
  ctrl_t           ch_ctrl  [NCH];
  logic [NCH-1:0]  ch_raw, ch_inten, ch_expire;
  logic [NCH-1:0]  irq_vec;

  dtb_decode u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .wr_acc(wr_acc), .hit_ch(hit_ch), .ch_sel(ch_sel), .ch_reg(ch_reg),
    .hit_iten(hit_iten), .hit_itov(hit_itov), .hit_id(hit_id),
    .id_idx(id_idx), .unmapped(unmapped)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic wr_this;
    assign wr_this = wr_acc && hit_ch && (ch_sel == CH_W'(i));
    dtb_channel u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_load  (wr_this && ch_reg == RG_LOAD),
      .wr_bgload(wr_this && ch_reg == RG_BGLOAD),
      .wr_ctrl  (wr_this && ch_reg == RG_CTRL),
      .wr_intclr(wr_this && ch_reg == RG_INTCLR),
      .wdata(pwdata),
      .load_o(ch_load[i]), .value_o(ch_value[i]), .ctrl_o(ch_ctrl[i]),
      .raw_o(ch_raw[i]), .ev_expire(ch_expire[i])
    );
    assign ch_inten[i] = ch_ctrl[i].irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      itm_en_q <= 1'b0;
      itov_q   <= '0;
    end else begin
      if (wr_acc && hit_iten) itm_en_q <= pwdata[0];
      if (wr_acc && hit_itov) itov_q   <= pwdata[NCH-1:0];
    end
  end

  always_comb begin
    prdata = '0;
    if (hit_ch) begin
      case (ch_reg)
        RG_LOAD, RG_BGLOAD: prdata = ch_load[ch_sel];
        RG_VALUE:           prdata = ch_value[ch_sel];
        RG_CTRL:            prdata = DW'(ch_ctrl[ch_sel]);
        RG_RIS:             prdata = DW'(ch_raw[ch_sel]);
        RG_MIS:             prdata = DW'(ch_raw[ch_sel] & ch_inten[ch_sel]);
        default:            prdata = '0;
      endcase
    end else if (hit_iten) begin
      prdata = DW'(itm_en_q);
    end else if (hit_itov) begin
      prdata = DW'(itov_q);
    end else if (hit_id) begin
      prdata = DW'(id_byte(id_idx));
    end
  end

  dtb_irq_out u_irq (
    .clk(clk), .rst_n(rst_n), .itm_en(itm_en_q), .itov(itov_q),
    .raw(ch_raw), .inten(ch_inten), .irq_q(irq_vec), .irq_any_q(tmr_irq_any)
  );

  assign tmr_irq_a = irq_vec[0];
  assign tmr_irq_b = irq_vec[1];
  assign pready    = 1'b1;
  assign pslverr   = 1'b0;
endmodule

// File: rtl/dtb_checker.sv
module dtb_checker
  import dtb_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           psel,
  input logic           penable,
  input logic           pwrite,
  input logic           pready,
  input logic           pslverr,
  input logic           unmapped,
  input logic [DW-1:0]  prdata,
  input logic [NCH-1:0] irq,
  input logic           irq_any,
  input logic           itm_en,
  input logic [NCH-1:0] itov,
  input logic [NCH-1:0] raw,
  input logic [NCH-1:0] inten,
  input logic [NCH-1:0] expire
);
  // R11
  zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr);

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !pwrite && unmapped) |-> (prdata == '0));

  // R8
  combined_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == (|irq));

  // R7
  override_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(itm_en) |-> (irq == $past(itov)));

  // R6
  masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(itm_en) |-> (irq == $past(raw & inten)));

  // R5
  expire_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|expire) |=> ((raw & $past(expire)) == $past(expire)));
endmodule

bind apb_dual_timer_bank dtb_checker u_dtb_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .pready(pready), .pslverr(pslverr), .unmapped(unmapped), .prdata(prdata),
  .irq(irq_vec), .irq_any(tmr_irq_any), .itm_en(itm_en_q), .itov(itov_q),
  .raw(ch_raw), .inten(ch_inten), .expire(ch_expire)
);

// File: tb/apb_dual_timer_bank_bench.sv
`timescale 1ns/1ps
module apb_dual_timer_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [9:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, tmr_irq_a, tmr_irq_b, tmr_irq_any;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  apb_dual_timer_bank u_apb_dual_timer_bank (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .tmr_irq_a(tmr_irq_a), .tmr_irq_b(tmr_irq_b),
    .tmr_irq_any(tmr_irq_any)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a[11:2]; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(posedge clk);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a[11:2];
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = prdata;
    chk("R11 ready/error", {30'b0, pready, pslverr}, 32'h2);
    @(posedge clk);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  // expected count and raw bit after n steps, from R4/R5
  function automatic logic [31:0] model(input logic [6:0] cfg, input logic [31:0] load,
                                        input int n, output logic ris);
    logic [31:0] m, c;
    m = cfg[2] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    c = load & m;
    ris = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (cfg[3] && c == 0) continue;
      if (c == 1) ris = 1'b1;
      if (c == 0) c = cfg[1] ? (load & m) : m;
      else c = c - 1;
    end
    return c;
  endfunction

  // runs a channel for k+3 edges, then reads value and raw status
  task automatic run_case(input int ch, input logic [6:0] cfg, input logic [31:0] load,
                          input int k, input string tag);
    logic [11:0] b;
    logic [31:0] v, r;
    logic eris;
    logic [31:0] ev;
    int div, steps;
    b = 12'(ch * 32);
    wr(b + 12'h08, {25'b0, cfg});
    wr(b + 12'h0C, 32'h0);
    wr(b + 12'h00, load);
    wr(b + 12'h08, {25'b0, cfg | 7'h01});
    repeat (k) @(negedge clk);
    wr(b + 12'h08, {25'b0, cfg});
    div = (cfg[6:5] == 0) ? 1 : (cfg[6:5] == 1) ? 16 : 256;
    steps = (k + 3) / div;
    ev = model(cfg, load, steps, eris);
    rd(b + 12'h04, v);
    chk(tag, v, ev);
    rd(b + 12'h10, r);
    chk({tag, " R5 raw"}, r, {31'b0, eris});
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    logic [6:0] cfgs [3];
    logic [31:0] loads [4];
    cfgs[0] = 7'h10; cfgs[1] = 7'h12; cfgs[2] = 7'h18;
    loads[0] = 32'd1; loads[1] = 32'd2; loads[2] = 32'd5; loads[3] = 32'h0001_0003;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int c = 0; c < 2; c++) begin
      rd(12'(c * 32 + 8), d);  chk("R1 ctrl reset", d, 32'h10);
      rd(12'(c * 32), d);      chk("R1 load reset", d, 32'h0);
      rd(12'(c * 32 + 4), d);  chk("R1 value reset", d, 32'hFFFF);
    end
    rd(12'hF00, d); chk("R1 override enable reset", d, 0);
    rd(12'hF04, d); chk("R1 override outputs reset", d, 0);
    chk("R1 irq lines reset", {29'b0, tmr_irq_a, tmr_irq_b, tmr_irq_any}, 0);

    // R2 addressing, load versus background load
    for (int c = 0; c < 2; c++) begin
      logic [11:0] b;
      b = 12'(c * 32);
      wr(b, 32'h1234_5678 + c);
      rd(b, d);            chk("R2 load readback", d, 32'h1234_5678 + c);
      rd(b + 12'h18, d);   chk("R2 bgload reads load", d, 32'h1234_5678 + c);
      rd(b + 12'h04, d);   chk("R2 load sets narrow count", d, 32'h5678 + c);
      wr(b + 12'h18, 32'hA5A5_0000 | c);
      rd(b, d);            chk("R2 bgload sets load", d, 32'hA5A5_0000 | c);
      rd(b + 12'h04, d);   chk("R2 bgload keeps count", d, 32'h5678 + c);
      wr(b + 12'h08, 32'hFFFF_FF7E);
      rd(b + 12'h08, d);   chk("R3 control keeps bits 6:0", d, 32'h7E);
      wr(b + 12'h08, 32'h10);
    end

    // R10 unmapped
    wr(12'h01C, 32'hFFFF_FFFF);
    wr(12'h040, 32'hFFFF_FFFF);
    rd(12'h01C, d); chk("R10 slot gap reads zero", d, 0);
    rd(12'h03C, d); chk("R10 slot gap ch1 reads zero", d, 0);
    rd(12'h040, d); chk("R10 beyond channels reads zero", d, 0);
    rd(12'hF08, d); chk("R10 after override reads zero", d, 0);
    rd(12'hFCC, d); chk("R10 below id reads zero", d, 0);
    rd(12'h000, d); chk("R10 write ignored, load intact", d, 32'hA5A5_0000);
    rd(12'h008, d); chk("R10 write ignored, ctrl intact", d, 32'h10);

    // R9 id bytes
    for (int i = 0; i < 12; i++) begin
      logic [7:0] e;
      case (i)
        0: e = 8'h04; 4: e = 8'h23; 5: e = 8'hB8; 6: e = 8'h1B;
        8: e = 8'h0D; 9: e = 8'hF0; 10: e = 8'h05; 11: e = 8'hB1;
        default: e = 8'h00;
      endcase
      rd(12'(12'hFD0 + 4 * i), d);
      chk("R9 id byte", d, {24'b0, e});
    end

    // R4 mode / width / load sweep, three steps each
    for (int c = 0; c < 2; c++)
      for (int w = 0; w < 2; w++)
        for (int m = 0; m < 3; m++)
          for (int l = 0; l < 4; l++)
            run_case(c, cfgs[m] | (w ? 7'h04 : 7'h00), loads[l], 0, "R4 count after steps");

    // R3 prescale boundaries
    run_case(0, 7'h34, 32'd10, 12, "R3 div16 before first step");
    run_case(0, 7'h34, 32'd10, 13, "R3 div16 first step");
    run_case(1, 7'h54, 32'd10, 252, "R3 div256 before first step");
    run_case(1, 7'h54, 32'd10, 253, "R3 div256 first step");
    run_case(0, 7'h74, 32'd10, 253, "R3 prescale 3 as 256");

    // R5 masked vs raw status
    run_case(0, 7'h04, 32'd2, 0, "R5 expiry with irq disabled");
    rd(12'h014, d); chk("R5 masked status off", d, 0);
    chk("R6 no line when disabled", {31'b0, tmr_irq_a}, 0);
    run_case(0, 7'h14, 32'd2, 0, "R5 expiry with irq enabled");
    rd(12'h014, d); chk("R5 masked status on", d, 1);
    wr(12'h00C, 32'h0);
    rd(12'h010, d); chk("R5 clear raw", d, 0);
    wr(12'h02C, 32'h0);
    repeat (2) @(negedge clk);

    // R6 exact latency: load 5, line rises 6 edges after run write
    wr(12'h020, 32'd5);
    wr(12'h028, 32'h1D);
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (i == 5) chk("R6 line low before due edge", {31'b0, tmr_irq_b}, 0);
      if (i == 6) begin
        chk("R6 line high on due edge", {31'b0, tmr_irq_b}, 1);
        chk("R8 combined follows", {31'b0, tmr_irq_any}, 1);
        chk("R6 other line quiet", {31'b0, tmr_irq_a}, 0);
      end
    end
    wr(12'h02C, 32'h0);
    chk("R6 line one edge after clear", {31'b0, tmr_irq_b}, 1);
    @(negedge clk);
    chk("R6 line dropped after clear", {31'b0, tmr_irq_b}, 0);
    chk("R8 combined dropped", {31'b0, tmr_irq_any}, 0);

    // R7 override
    wr(12'hF00, 32'hFFFF_FFFF);
    rd(12'hF00, d); chk("R7 enable keeps bit 0", d, 1);
    wr(12'hF04, 32'hFFFF_FFFD);
    chk("R7 lines wait one edge", {30'b0, tmr_irq_b, tmr_irq_a}, 0);
    @(negedge clk);
    chk("R7 lines driven by override", {30'b0, tmr_irq_b, tmr_irq_a}, 2'b01);
    chk("R8 combined under override", {31'b0, tmr_irq_any}, 1);
    rd(12'hF04, d); chk("R7 outputs keep bits 1:0", d, 1);
    wr(12'hF04, 32'h2);
    @(negedge clk);
    chk("R7 lines follow override", {30'b0, tmr_irq_b, tmr_irq_a}, 2'b10);
    wr(12'hF00, 32'h0);
    @(negedge clk);
    chk("R7 override released", {29'b0, tmr_irq_b, tmr_irq_a, tmr_irq_any}, 0);

    // R11 setup phase alone writes nothing
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 10'h000; pwdata = 32'hDEAD_BEEF;
    @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
    rd(12'h000, d); chk("R11 setup-only write ignored", d, 32'd2);

    done = 1'b1;
    finish_run();
  end
endmodule